// File: doc/BRIEF.md
# PDM-Domain Delay-and-Sum Combiner

This block steers a microphone array while the signals are still one-bit pulse-density streams. Every channel bit arrives on a shared sample enable. Each channel is delayed by its own whole number of samples, and its unit gain turns the weighting step into a plain add. The delayed bits are then summed into one signed value per sample. Summing before any filtering means one decimation path serves the whole array, instead of one filter per microphone.

The per-sample sum feeds a reduced decimator. This decimator accumulates DEC consecutive sums and dumps the total once per frame, with a single-cycle strobe.

Delays are set through a small write port. A written value is staged and only takes effect at a frame boundary, so a frame is never computed with two different steering settings.

Top module: `beam_combiner`

## Requirements
- R1: While reset is asserted, and after it until the first enabled sample, beam_sum, dec_data and dec_valid are 0. Every channel delay resets to 0.
- R2: On each clock edge with pdm_en high, beam_sum is loaded with the sum over all channels of the delayed bit of that sample. A delayed bit of 1 counts as +1 and a delayed bit of 0 counts as -1. The new value is visible in the following cycle.
- R3: A channel with active delay d, where d runs from 0 to 2^DLW-1, contributes the bit it received d enabled samples earlier. A delay of 0 uses the bit presented in the same sample.
- R4: If fewer than d enabled samples have occurred since reset, a channel with delay d contributes -1.
- R5: A delay write (cfg_we high, channel cfg_ch, value cfg_dly) is staged. It becomes active from the first sample of the next frame. A write made in the same cycle as a frame's last sample takes effect one frame later. A write naming a channel index of NCH or more is ignored.
- R6: Frames are runs of DEC enabled samples, counted from reset. The cycle after a frame's last sample, dec_valid is high for exactly one cycle and dec_data holds the sum of that frame's DEC beam_sum values. dec_valid is low in every other cycle.
- R7: dec_data keeps its value between dec_valid pulses.
- R8: In a cycle with pdm_en low, no history, delay activation, frame count or sum advances. beam_sum holds its value and dec_valid stays low.
- R9: When the channel delays cancel the per-channel arrival offsets of a common source, every per-sample sum has magnitude NCH. The frame energy is then NCH*NCH*DEC, which is greater than the energy of the same signals without alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pdm_en | input | 1 | Sample enable shared by all channels |
| pdm_in | input | NCH | One PDM bit per channel |
| cfg_we | input | 1 | Delay write strobe |
| cfg_ch | input | max(1, clog2(NCH)) | Channel index of the write |
| cfg_dly | input | DLW | Delay value in samples |
| beam_sum | output | clog2(NCH+1)+1 | Signed per-sample array sum |
| dec_data | output | clog2(NCH*DEC+1)+1 | Signed frame total |
| dec_valid | output | 1 | One-cycle strobe for a new frame total |

## Verification
- **Timing of results.** beam_sum is due in the cycle after an enabled sample edge. The dec_valid pulse and the new dec_data are due in the cycle after the DEC-th enabled sample of a frame. A staged delay first changes beam_sum in the cycle after the first enabled sample of the following frame.
- **How the bench samples.** The bench drives inputs on the falling edge and reads every output 1 ns after the next rising edge. Its model is updated per enabled sample in the same order, so each comparison falls in exactly the cycle where the result is due.
- **Idle cycles.** Cycles with pdm_en low are checked for held outputs in the same way.

// File: rtl/beam_combiner.sv
module beam_combiner #(
  parameter int NCH = 40,
  parameter int DLW = 6,
  parameter int DEC = 192,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int DEPTH = 1 << DLW,
  localparam int CW = $clog2(DEC),
  localparam int SW = $clog2(NCH + 1) + 1,
  localparam int PW = SW - 1,
  localparam int AW = $clog2(NCH * DEC + 1) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  pdm_en,
  input  logic [NCH-1:0]        pdm_in,
  input  logic                  cfg_we,
  input  logic [CHW-1:0]        cfg_ch,
  input  logic [DLW-1:0]        cfg_dly,
  output logic signed [SW-1:0]  beam_sum,
  output logic signed [AW-1:0]  dec_data,
  output logic                  dec_valid
);

  logic [NCH-1:0] hist [DEPTH];
  logic [DLW-1:0] wp, fill;
  logic [CW-1:0]  fcnt;
  logic [DLW-1:0] pend_dly [NCH];
  logic [DLW-1:0] act_dly [NCH];
  logic [NCH-1:0] dbit;
  logic [PW-1:0]  pop;
  logic signed [SW-1:0] samp;
  logic signed [AW-1:0] acc, acc_nxt;
  logic frame_end;

  assign frame_end = pdm_en && (fcnt == CW'(DEC - 1));

  for (genvar c = 0; c < NCH; c++) begin : g_tap
    logic [DLW-1:0] rd;
    assign rd = wp - act_dly[c];
    assign dbit[c] = (act_dly[c] == '0) ? pdm_in[c]
                   : ((fill >= act_dly[c]) && hist[rd][c]);
  end

  always_comb begin
    pop = '0;
    for (int c = 0; c < NCH; c++) pop = pop + PW'(dbit[c]);
  end

  assign samp    = $signed({pop, 1'b0}) - $signed(SW'(NCH));
  assign acc_nxt = acc + AW'(samp);

  always_ff @(posedge clk) begin
    if (pdm_en) hist[wp] <= pdm_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      fill      <= '0;
      fcnt      <= '0;
      acc       <= '0;
      beam_sum  <= '0;
      dec_data  <= '0;
      dec_valid <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        pend_dly[c] <= '0;
        act_dly[c]  <= '0;
      end
    end else begin
      dec_valid <= frame_end;
      if (cfg_we && (int'(cfg_ch) < NCH)) pend_dly[cfg_ch] <= cfg_dly;
      if (pdm_en) begin
        wp       <= wp + 1'b1;
        beam_sum <= samp;
        if (fill != '1) fill <= fill + 1'b1;
        if (frame_end) begin
          fcnt     <= '0;
          acc      <= '0;
          dec_data <= acc_nxt;
          for (int c = 0; c < NCH; c++) act_dly[c] <= pend_dly[c];
        end else begin
          fcnt <= fcnt + 1'b1;
          acc  <= acc_nxt;
        end
      end
    end
  end

endmodule

module beam_chk #(
  parameter int NCH = 40,
  parameter int DEC = 192,
  parameter int SW = 7,
  parameter int AW = 14
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pdm_en,
  input logic signed [SW-1:0] beam_sum,
  input logic signed [AW-1:0] dec_data,
  input logic                 dec_valid
);

  int en_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) en_cnt <= 0;
    else if (dec_valid) en_cnt <= pdm_en ? 1 : 0;
    else if (pdm_en) en_cnt <= en_cnt + 1;
  end

  // R6
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (en_cnt == DEC));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R6
  dec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> ((dec_data <= NCH * DEC) && (dec_data >= -(NCH * DEC))));

  // R7
  dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> $stable(dec_data));

  // R8
  sum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdm_en |=> $stable(beam_sum));

  // R8
  idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pdm_en |=> !dec_valid);

  // R2
  sum_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pdm_en |=> ((beam_sum[0] == 1'(NCH % 2)) && (beam_sum <= NCH) && (beam_sum >= -NCH)));

endmodule

bind beam_combiner beam_chk #(.NCH(NCH), .DEC(DEC), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pdm_en(pdm_en), .beam_sum(beam_sum),
  .dec_data(dec_data), .dec_valid(dec_valid)
);

// File: tb/sim_beam_combiner.sv
`timescale 1ns/1ps
module sim_beam_combiner;
  localparam int NCH = 4;
  localparam int DLW = 4;
  localparam int DEC = 8;
  localparam int CHW = 2;
  localparam int SW = $clog2(NCH + 1) + 1;
  localparam int AW = $clog2(NCH * DEC + 1) + 1;
  localparam int HL = 2048;

  logic clk = 0, rst_n = 0, pdm_en = 0, cfg_we = 0;
  logic [NCH-1:0] pdm_in = '0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [DLW-1:0] cfg_dly = '0;
  logic signed [SW-1:0] beam_sum;
  logic signed [AW-1:0] dec_data;
  logic dec_valid;

  beam_combiner #(.NCH(NCH), .DLW(DLW), .DEC(DEC)) u0 (
    .clk(clk), .rst_n(rst_n), .pdm_en(pdm_en), .pdm_in(pdm_in),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_dly(cfg_dly),
    .beam_sum(beam_sum), .dec_data(dec_data), .dec_valid(dec_valid));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit inh [NCH][HL];
  int act [NCH];
  int pend [NCH];
  int n, acc, e_sum, e_dec, e_val;
  logic [31:0] rnd = 32'h1234_5679;
  bit pbase [HL];
  int off [NCH];

  task automatic chk(string tag, int a, int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, a, e);
    end
  endtask

  task automatic next_rnd();
    rnd = rnd ^ (rnd << 13);
    rnd = rnd ^ (rnd >> 17);
    rnd = rnd ^ (rnd << 5);
  endtask

  task automatic model_reset();
    n = 0; acc = 0; e_sum = 0; e_dec = 0; e_val = 0;
    for (int c = 0; c < NCH; c++) begin act[c] = 0; pend[c] = 0; end
  endtask

  task automatic step(input logic [NCH-1:0] bits, input bit en, input bit we,
                      input int ch, input int d, input string tag);
    @(negedge clk);
    pdm_in = bits; pdm_en = en; cfg_we = we;
    cfg_ch = CHW'(ch); cfg_dly = DLW'(d);
    @(posedge clk);
    #1;
    e_val = 0;
    if (en) begin
      e_sum = 0;
      for (int c = 0; c < NCH; c++) begin
        bit b;
        inh[c][n] = bits[c];
        b = (n >= act[c]) ? inh[c][n - act[c]] : 1'b0;
        e_sum += b ? 1 : -1;
      end
      acc += e_sum;
      if (n % DEC == DEC - 1) begin
        e_val = 1; e_dec = acc; acc = 0;
        for (int c = 0; c < NCH; c++) act[c] = pend[c];
      end
      n++;
    end
    if (we && ch < NCH) pend[ch] = d;
    chk(en ? tag : "R8", int'(beam_sum), e_sum);
    chk("R6", int'(dec_valid), e_val);
    chk(e_val ? "R6" : "R7", int'(dec_data), e_dec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; pdm_en = 0; cfg_we = 0; pdm_in = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", int'(beam_sum), 0);
    chk("R1", int'(dec_valid), 0);
    chk("R1", int'(dec_data), 0);
    @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic rnd_bits(output logic [NCH-1:0] b);
    next_rnd();
    b = rnd[NCH+3:4];
  endtask

  initial begin
    logic [NCH-1:0] b;
    int e0, e1;
    model_reset();
    do_reset();
    step('0, 0, 0, 0, 0, "R1");

    // R2 R6 R7: zero delays, random bits, continuous enable
    for (int i = 0; i < 3 * DEC; i++) begin
      rnd_bits(b);
      step(b, 1, 0, 0, 0, "R2");
    end

    // R3 R5 R8: delay sweep with mid-frame writes and idle gaps
    for (int k = 0; k < 16; k++) begin
      for (int c = 0; c < NCH; c++) begin
        rnd_bits(b);
        step(b, 0, 1, c, (k + 5 * c) % 16, "R5");
      end
      for (int i = 0; i < 2 * DEC + 4; i++) begin
        rnd_bits(b);
        next_rnd();
        step(b, rnd[7:6] != 2'b00, 0, 0, 0, "R3");
      end
    end

    // R5: write coinciding with a frame's last sample
    while (n % DEC != DEC - 1) begin
      rnd_bits(b);
      step(b, 1, 0, 0, 0, "R5");
    end
    rnd_bits(b);
    step(b, 1, 1, 1, 9, "R5");
    for (int i = 0; i < 2 * DEC; i++) begin
      rnd_bits(b);
      step(b, 1, 0, 0, 0, "R5");
    end

    // R4: fill masking after reset, all-ones input
    do_reset();
    step('1, 0, 1, 0, 15, "R4");
    for (int i = 0; i < 3 * DEC; i++) step('1, 1, 0, 0, 0, "R4");

    // R9: common source with per-channel arrival offsets
    do_reset();
    off[0] = 0; off[1] = 3; off[2] = 7; off[3] = 11;
    e0 = 0; e1 = 0;
    for (int i = 0; i < 5 * DEC; i++) begin
      next_rnd();
      pbase[n] = rnd[9];
      for (int c = 0; c < NCH; c++)
        b[c] = (n >= off[c]) ? pbase[n - off[c]] : 1'b0;
      if (i == 2 * DEC + 1) begin
        for (int c = 0; c < NCH; c++) step('0, 0, 1, c, 11 - off[c], "R9");
      end
      step(b, 1, 0, 0, 0, "R9");
      if (i >= 2 * DEC && i < 3 * DEC) e0 += int'(beam_sum) * int'(beam_sum);
      if (i >= 4 * DEC) e1 += int'(beam_sum) * int'(beam_sum);
    end
    chk("R9", e1, NCH * NCH * DEC);
    chk("R9", int'(e1 > e0), 1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule